// File: doc/BRIEF.md
# Low-Voltage Detect Control Logic

This block is the digital side of a supply-voltage monitor. Two analog comparators report "supply below the detect level" and "supply below the warning level". The block brings both signals into the clock domain, detects their onsets and turns them into three outputs: a system reset request, a detect interrupt and an early-warning interrupt. It also keeps a sticky status bit that records that the last reset came from power-on or from the voltage monitor. Trip points are chosen by two select bits, which the block drives out to the analog side.

Software reaches the block through a small 8-bit register port with three addresses. Address 0 holds the detect controls, address 1 holds the warning controls and address 2 holds the reset-source bit. Each flag is cleared by writing 1 to an acknowledge bit next to it. In reset mode the request stays high for as long as the supply stays below the detect level.

Top module: `lvd_ctrl`

## Requirements
- R1: On `por` every register returns to its default and the reset-source bit becomes 1. Address 0 reads 0x18, which means detect enable and reset enable are set. On `rst` without `por` the same defaults load, except that the reset-source bit becomes 0. After either reset all request and interrupt outputs are 0.
- R2: Each comparator input passes through a two-flop synchronizer. A change sampled at clock edge k first reaches the flags and the reset request at edge k+2.
- R3: The reset request goes high when the synchronized detect input is 1 while detect enable (address 0 bit 3) and reset enable (address 0 bit 4) are both 1. Once high, it stays high whatever the enables are, for as long as the synchronized detect input stays 1. It drops on the first edge at which that input is 0.
- R4: The reset-source bit (address 2 bit 0, also on `lvd_src_o`) is 1 whenever the reset request is 1. Any write to address 2 clears it, unless the reset request is high in that cycle; in that case the set wins.
- R5: The detect flag (address 0 bit 7, read-only) is set on a rising edge of the synchronized detect input when detect enable is 1 and reset enable is 0. `det_irq_o` equals the flag ANDed with detect interrupt enable (address 0 bit 5). A level that stays low does not set the flag again.
- R6: Writing address 0 with bit 6 set clears the detect flag. Bit 6 always reads 0. If a set event and this write happen in the same cycle, the flag stays 1.
- R7: The warning flag (address 1 bit 7) is set on a rising edge of the synchronized warning input while detect enable is 1. `warn_irq_o` equals the flag ANDed with address 1 bit 5. Writing address 1 with bit 6 set clears the flag, and a set in the same cycle wins.
- R8: `det_vsel_o` follows address 0 bit 0 and `warn_vsel_o` follows address 1 bit 0.
- R9: Bits not listed above read 0. Address 3 reads 0, and writes to it change nothing.
- R10: With detect enable 0, neither flag is set and the reset request does not assert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset from any source other than power-on, active high |
| por | input | 1 | Power-on reset indication, active high |
| det_low_i | input | 1 | Asynchronous detect comparator output, 1 = supply below detect level |
| warn_low_i | input | 1 | Asynchronous warning comparator output, 1 = supply below warning level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| rst_req_o | output | 1 | System reset request |
| det_irq_o | output | 1 | Detect interrupt request |
| warn_irq_o | output | 1 | Warning interrupt request |
| det_vsel_o | output | 1 | Detect threshold select to the analog side |
| warn_vsel_o | output | 1 | Warning trip-point select to the analog side |
| lvd_src_o | output | 1 | Reset-source status bit |

## Verification
A behavioural model runs alongside the design and is compared with it on every clock. The detect input is tried in several ways:
- A single slow edge measures the synchronizer latency.
- A level held high after an acknowledge shows that the flag is edge-set rather than level-set.
- An edge timed to coincide with an acknowledge write shows whether the set or the clear wins.
- A dip in reset mode, during which the enables are cleared, shows whether the request is held by the supply level or by the enable bits.

The same pulses with detect enable off, and writes to the unused address, separate real gating from outputs that merely happen to be quiet.

// File: rtl/lvd_pkg.sv
package lvd_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_WARN = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    // field positions shared by the control and warning registers
    localparam int B_FLAG = 7;
    localparam int B_ACK  = 6;
    localparam int B_IE   = 5;
    localparam int B_RSTE = 4;
    localparam int B_EN   = 3;
    localparam int B_VSEL = 0;
    localparam int B_SRC  = 0;

    typedef struct packed {
        logic en;
        logic rste;
        logic ie;
        logic vsel;
    } det_cfg_t;

    typedef struct packed {
        logic ie;
        logic vsel;
    } warn_cfg_t;

    typedef struct packed {
        logic det_ack;
        logic warn_ack;
        logic stat_wr;
    } reg_evt_t;

    function automatic det_cfg_t det_cfg_default();
        det_cfg_t c;
        c.en   = 1'b1;
        c.rste = 1'b1;
        c.ie   = 1'b0;
        c.vsel = 1'b0;
        return c;
    endfunction

    function automatic warn_cfg_t warn_cfg_default();
        warn_cfg_t c;
        c.ie   = 1'b0;
        c.vsel = 1'b0;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(det_cfg_t c, logic flag);
        logic [DATA_W-1:0] d;
        d         = '0;
        d[B_FLAG] = flag;
        d[B_IE]   = c.ie;
        d[B_RSTE] = c.rste;
        d[B_EN]   = c.en;
        d[B_VSEL] = c.vsel;
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] pack_warn(warn_cfg_t c, logic flag);
        logic [DATA_W-1:0] d;
        d         = '0;
        d[B_FLAG] = flag;
        d[B_IE]   = c.ie;
        d[B_VSEL] = c.vsel;
        return d;
    endfunction

endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (clr) chain[0] <= '0;
        else     chain[0] <= async_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (clr) chain[g] <= '0;
            else     chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (clr) prev_q <= '0;
        else     prev_q <= chain[STAGES-1];
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_chk
        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (clr)
            rise_o[b] |=> !rise_o[b]);  // R2
    end

endmodule

// File: rtl/lvd_regs.sv
module lvd_regs
    import lvd_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              det_flag_i,
    input  logic              warn_flag_i,
    input  logic              src_i,
    output det_cfg_t          det_cfg_o,
    output warn_cfg_t         warn_cfg_o,
    output reg_evt_t          evt_o,
    output logic [DATA_W-1:0] rdata_o
);

    det_cfg_t  det_q;
    warn_cfg_t warn_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            det_q  <= det_cfg_default();
            warn_q <= warn_cfg_default();
        end else if (wr_i) begin
            if (addr_i == ADDR_CTRL) begin
                det_q.en   <= wdata_i[B_EN];
                det_q.rste <= wdata_i[B_RSTE];
                det_q.ie   <= wdata_i[B_IE];
                det_q.vsel <= wdata_i[B_VSEL];
            end
            if (addr_i == ADDR_WARN) begin
                warn_q.ie   <= wdata_i[B_IE];
                warn_q.vsel <= wdata_i[B_VSEL];
            end
        end
    end

    // R6 R7: acknowledge strobes are decoded, never stored
    always_comb begin
        evt_o.det_ack  = wr_i && (addr_i == ADDR_CTRL) && wdata_i[B_ACK];
        evt_o.warn_ack = wr_i && (addr_i == ADDR_WARN) && wdata_i[B_ACK];
        evt_o.stat_wr  = wr_i && (addr_i == ADDR_STAT);
    end

    // R9: read map
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_CTRL: rdata_o = pack_ctrl(det_q, det_flag_i);
            ADDR_WARN: rdata_o = pack_warn(warn_q, warn_flag_i);
            ADDR_STAT: rdata_o[B_SRC] = src_i;
            default:   rdata_o = '0;
        endcase
    end

    assign det_cfg_o  = det_q;
    assign warn_cfg_o = warn_q;

    AST_ACK_NOT_STORED: assert property (@(posedge clk) disable iff (clr)
        (addr_i == ADDR_CTRL) |-> !rdata_o[B_ACK]);  // R6

endmodule

// File: rtl/lvd_core.sv
module lvd_core
    import lvd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      por,
    input  det_cfg_t  det_cfg_i,
    input  warn_cfg_t warn_cfg_i,
    input  reg_evt_t  evt_i,
    input  logic      det_lvl_i,
    input  logic      det_rise_i,
    input  logic      warn_rise_i,
    output logic      det_flag_o,
    output logic      warn_flag_o,
    output logic      src_o,
    output logic      rst_req_o,
    output logic      det_irq_o,
    output logic      warn_irq_o
);

    logic rst_req_q, rst_req_d;
    logic det_flag_q, det_flag_d;
    logic warn_flag_q, warn_flag_d;
    logic src_q, src_d;
    logic det_set, warn_set;

    always_comb begin
        det_set     = det_rise_i && det_cfg_i.en && !det_cfg_i.rste;              // R5
        warn_set    = warn_rise_i && det_cfg_i.en;                                // R7
        rst_req_d   = det_lvl_i && (rst_req_q || (det_cfg_i.en && det_cfg_i.rste)); // R3
        det_flag_d  = det_set  || (det_flag_q  && !evt_i.det_ack);                // R6
        warn_flag_d = warn_set || (warn_flag_q && !evt_i.warn_ack);
        if (rst_req_d)          src_d = 1'b1;                                     // R4
        else if (evt_i.stat_wr) src_d = 1'b0;
        else                    src_d = src_q;
    end

    always_ff @(posedge clk) begin
        if (por || rst) begin
            rst_req_q   <= 1'b0;
            det_flag_q  <= 1'b0;
            warn_flag_q <= 1'b0;
            src_q       <= por;                                                   // R1
        end else begin
            rst_req_q   <= rst_req_d;
            det_flag_q  <= det_flag_d;
            warn_flag_q <= warn_flag_d;
            src_q       <= src_d;
        end
    end

    assign det_flag_o  = det_flag_q;
    assign warn_flag_o = warn_flag_q;
    assign src_o       = src_q;
    assign rst_req_o   = rst_req_q;
    assign det_irq_o   = det_flag_q && det_cfg_i.ie;
    assign warn_irq_o  = warn_flag_q && warn_cfg_i.ie;

    AST_RREQ_HOLD: assert property (@(posedge clk) disable iff (rst || por)
        rst_req_q && det_lvl_i |=> rst_req_q);  // R3
    AST_RREQ_RELEASE: assert property (@(posedge clk) disable iff (rst || por)
        !det_lvl_i |=> !rst_req_q);  // R3
    AST_RREQ_GATED: assert property (@(posedge clk) disable iff (rst || por)
        !rst_req_q && !(det_cfg_i.en && det_cfg_i.rste) |=> !rst_req_q);  // R10
    AST_SRC_COVERS: assert property (@(posedge clk) disable iff (rst || por)
        rst_req_q |-> src_q);  // R4
    AST_DET_SET_WINS: assert property (@(posedge clk) disable iff (rst || por)
        det_rise_i && det_cfg_i.en && !det_cfg_i.rste |=> det_flag_q);  // R6
    AST_DET_ACK_CLR: assert property (@(posedge clk) disable iff (rst || por)
        evt_i.det_ack && !(det_rise_i && det_cfg_i.en && !det_cfg_i.rste) |=> !det_flag_q);  // R6
    AST_WARN_SET: assert property (@(posedge clk) disable iff (rst || por)
        warn_rise_i && det_cfg_i.en |=> warn_flag_q);  // R7
    AST_NO_FLAG_DISABLED: assert property (@(posedge clk) disable iff (rst || por)
        !det_cfg_i.en && !det_flag_q |=> !det_flag_q);  // R10

endmodule

// File: rtl/lvd_ctrl.sv
module lvd_ctrl
    import lvd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic        det_low_i,
    input  logic        warn_low_i,
    input  logic        reg_wr_i,
    input  logic [1:0]  reg_addr_i,
    input  logic [7:0]  reg_wdata_i,
    output logic [7:0]  reg_rdata_o,
    output logic        rst_req_o,
    output logic        det_irq_o,
    output logic        warn_irq_o,
    output logic        det_vsel_o,
    output logic        warn_vsel_o,
    output logic        lvd_src_o
);

    localparam int NCMP  = 2;
    localparam int I_DET = 0;
    localparam int I_WRN = 1;

    logic            clr;
    logic [NCMP-1:0] cmp_lvl, cmp_rise;
    det_cfg_t        det_cfg;
    warn_cfg_t       warn_cfg;
    reg_evt_t        evt;
    logic            det_flag, warn_flag, src;

    assign clr = rst || por;

    lvd_sync #(.WIDTH(NCMP), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .clr     (clr),
        .async_i ({warn_low_i, det_low_i}),
        .level_o (cmp_lvl),
        .rise_o  (cmp_rise)
    );

    lvd_regs u_regs (
        .clk         (clk),
        .clr         (clr),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .det_flag_i  (det_flag),
        .warn_flag_i (warn_flag),
        .src_i       (src),
        .det_cfg_o   (det_cfg),
        .warn_cfg_o  (warn_cfg),
        .evt_o       (evt),
        .rdata_o     (reg_rdata_o)
    );

    lvd_core u_core (
        .clk         (clk),
        .rst         (rst),
        .por         (por),
        .det_cfg_i   (det_cfg),
        .warn_cfg_i  (warn_cfg),
        .evt_i       (evt),
        .det_lvl_i   (cmp_lvl[I_DET]),
        .det_rise_i  (cmp_rise[I_DET]),
        .warn_rise_i (cmp_rise[I_WRN]),
        .det_flag_o  (det_flag),
        .warn_flag_o (warn_flag),
        .src_o       (src),
        .rst_req_o   (rst_req_o),
        .det_irq_o   (det_irq_o),
        .warn_irq_o  (warn_irq_o)
    );

    assign det_vsel_o  = det_cfg.vsel;   // R8
    assign warn_vsel_o = warn_cfg.vsel;  // R8
    assign lvd_src_o   = src;

endmodule

// File: tb/lvd_ctrl_tb.sv
`timescale 1ns/1ps
module lvd_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       por = 1'b1;
    logic       det_low = 1'b0;
    logic       warn_low = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rst_req, det_irq, warn_irq, det_vsel, warn_vsel, lvd_src;

    always #2 clk = ~clk;

    lvd_ctrl u_dut (
        .clk(clk), .rst(rst), .por(por),
        .det_low_i(det_low), .warn_low_i(warn_low),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .rst_req_o(rst_req),
        .det_irq_o(det_irq), .warn_irq_o(warn_irq),
        .det_vsel_o(det_vsel), .warn_vsel_o(warn_vsel), .lvd_src_o(lvd_src)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit m_en, m_rste, m_ie, m_dv, m_df, m_wie, m_wv, m_wf, m_src, m_rr;
    bit qd[$];
    bit qw[$];
    bit m_valid = 1'b0;

    always @(posedge clk) begin
        bit ds, drise, wrise, rr_n, dack, wack, swr;
        if (por || rst) begin
            m_en = 1; m_rste = 1; m_ie = 0; m_dv = 0; m_df = 0;
            m_wie = 0; m_wv = 0; m_wf = 0; m_rr = 0;
            m_src = por;
            qd = '{0, 0, 0};
            qw = '{0, 0, 0};
            m_valid = 1'b1;
        end else if (m_valid) begin
            ds    = qd[1];
            drise = qd[1] && !qd[0];
            wrise = qw[1] && !qw[0];
            qd.push_back(det_low);  void'(qd.pop_front());
            qw.push_back(warn_low); void'(qw.pop_front());
            dack = reg_wr && reg_addr == 2'd0 && reg_wdata[6];
            wack = reg_wr && reg_addr == 2'd1 && reg_wdata[6];
            swr  = reg_wr && reg_addr == 2'd2;
            rr_n = ds && (m_rr || (m_en && m_rste));
            m_df = (drise && m_en && !m_rste) || (m_df && !dack);
            m_wf = (wrise && m_en) || (m_wf && !wack);
            m_src = rr_n ? 1'b1 : (swr ? 1'b0 : m_src);
            m_rr = rr_n;
            if (reg_wr && reg_addr == 2'd0) begin
                m_ie = reg_wdata[5]; m_rste = reg_wdata[4];
                m_en = reg_wdata[3]; m_dv = reg_wdata[0];
            end
            if (reg_wr && reg_addr == 2'd1) begin
                m_wie = reg_wdata[5]; m_wv = reg_wdata[0];
            end
        end
    end

    function automatic logic [7:0] model_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return {m_df, 1'b0, m_ie, m_rste, m_en, 2'b00, m_dv};
            2'd1:    return {m_wf, 1'b0, m_wie, 4'b0000, m_wv};
            2'd2:    return {7'b0, m_src};
            default: return 8'h00;
        endcase
    endfunction

    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk("R3", "rst_req", rst_req, m_rr);
            chk("R5", "det_irq", det_irq, m_df && m_ie);
            chk("R7", "warn_irq", warn_irq, m_wf && m_wie);
            chk("R8", "det_vsel", det_vsel, m_dv);
            chk("R8", "warn_vsel", warn_vsel, m_wv);
            chk("R4", "lvd_src", lvd_src, m_src);
            chk("R9", "rdata", reg_rdata, model_rdata(reg_addr));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        step(1);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        @(negedge clk);
        chk(req, "read", reg_rdata, exp);
        step(1);
    endtask

    task automatic at_neg(input string req, input string what, input int act_sel, input int exp);
        @(negedge clk);
        case (act_sel)
            0: chk(req, what, rst_req, exp);
            1: chk(req, what, det_irq, exp);
            2: chk(req, what, warn_irq, exp);
            3: chk(req, what, lvd_src, exp);
            4: chk(req, what, det_vsel, exp);
            default: chk(req, what, warn_vsel, exp);
        endcase
    endtask

    initial begin
        step(3);
        por = 1'b0;
        // R1: power-on defaults
        at_neg("R1", "rst_req after por", 0, 0);
        at_neg("R1", "src after por", 3, 1);
        rd_chk("R1", 2'd0, 8'h18);
        rd_chk("R1", 2'd1, 8'h00);

        // R2: latency through the synchronizer, interrupt mode
        wr_reg(2'd0, 8'h28);
        step(1);
        det_low = 1'b1;
        at_neg("R2", "irq before edge k", 1, 0);
        step(2);
        at_neg("R2", "irq after edge k+1", 1, 0);
        step(1);
        at_neg("R5", "irq after edge k+2", 1, 1);

        // R6: ack with level still low, no re-set
        wr_reg(2'd0, 8'h68);
        step(4);
        at_neg("R6", "flag stays clear on held level", 1, 0);
        rd_chk("R6", 2'd0, 8'h28);
        det_low = 1'b0;
        step(4);

        // R6: set and ack in the same cycle
        det_low = 1'b1;
        step(2);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h68;
        step(1);
        reg_wr = 1'b0;
        at_neg("R6", "set wins over ack", 1, 1);
        wr_reg(2'd0, 8'h68);
        at_neg("R6", "ack clears", 1, 0);
        det_low = 1'b0;
        step(4);

        // R7: warning flag and ack
        wr_reg(2'd1, 8'h21);
        warn_low = 1'b1;
        step(4);
        at_neg("R7", "warn irq", 2, 1);
        warn_low = 1'b0;
        wr_reg(2'd1, 8'h61);
        at_neg("R7", "warn ack", 2, 0);
        rd_chk("R7", 2'd1, 8'h21);

        // R3 R4: reset mode, held by level, released on recovery
        wr_reg(2'd0, 8'h18);
        det_low = 1'b1;
        step(4);
        at_neg("R3", "rst_req asserted", 0, 1);
        rd_chk("R4", 2'd2, 8'h01);
        wr_reg(2'd0, 8'h00);
        step(2);
        at_neg("R3", "rst_req held after enables cleared", 0, 1);
        wr_reg(2'd2, 8'h00);
        at_neg("R4", "set beats status write", 3, 1);
        det_low = 1'b0;
        step(2);
        at_neg("R3", "still held before k+2", 0, 1);
        step(1);
        at_neg("R3", "released", 0, 0);
        wr_reg(2'd2, 8'h00);
        at_neg("R4", "status write clears", 3, 0);

        // R1: other reset source
        wr_reg(2'd1, 8'h01);
        step(1);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        at_neg("R1", "src after rst", 3, 0);
        at_neg("R1", "warn_vsel after rst", 5, 0);
        rd_chk("R1", 2'd0, 8'h18);

        // R10: detect disabled
        wr_reg(2'd0, 8'h20);
        wr_reg(2'd1, 8'h20);
        det_low = 1'b1; warn_low = 1'b1;
        step(5);
        at_neg("R10", "no det irq", 1, 0);
        at_neg("R10", "no warn irq", 2, 0);
        at_neg("R10", "no rst_req", 0, 0);
        rd_chk("R10", 2'd0, 8'h20);
        det_low = 1'b0; warn_low = 1'b0;
        step(4);

        // R9: unused address
        wr_reg(2'd3, 8'hFF);
        rd_chk("R9", 2'd3, 8'h00);
        rd_chk("R9", 2'd0, 8'h20);

        // R8: select outputs
        wr_reg(2'd0, 8'h01);
        at_neg("R8", "det_vsel", 4, 1);
        wr_reg(2'd1, 8'h01);
        at_neg("R8", "warn_vsel", 5, 1);
        step(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule